// File: doc/BRIEF.md
# Block-Write Configuration I2C Slave

This block is an I2C target that holds seven byte-wide configuration registers for a clock generator and presents them as parallel control buses. It answers to the 7-bit bus address 0x69: address byte 0xD2 for writes, 0xD3 for reads. A write carries two leading bytes, a command code and a byte count. Both are acknowledged and then dropped. Every later data byte lands in the next register, starting at register 0 and counting upward, until STOP. A read streams the registers back from register 0 upward. No count byte is sent first, and the stream runs until the controller answers NACK.

SCL and SDA are sampled on the system clock through two-flop synchronizers. The system clock must run at least 16 times the bit rate. The standard target rate is 100 kbit/s. START is an SDA fall and STOP an SDA rise, each while SCL stays high. The slave only pulls SDA low and never drives it high. The `pd_hiz` input models the power-down tristate condition: it parks the controller, releases SDA and freezes the registers.

The controller has twelve states:
- ST_IDLE waits for START.
- ST_ADDR shifts in the address byte.
- ST_ADDR_ACK acknowledges it.
- ST_CMD / ST_CMD_ACK take the command code.
- ST_CNT / ST_CNT_ACK take the byte count.
- ST_WDATA / ST_WDATA_ACK take and store data bytes.
- ST_RDATA shifts a byte out.
- ST_RACK samples the controller's acknowledge.
- ST_SKIP ignores traffic until STOP.

The transitions are:
- START leads from any state to ST_ADDR.
- STOP leads to ST_IDLE.
- `pd_hiz` forces ST_IDLE.
- ST_ADDR goes to ST_ADDR_ACK on an address match and to ST_SKIP otherwise.
- ST_ADDR_ACK goes to ST_CMD for a write and to ST_RDATA for a read.
- The write path runs CMD_ACK → CNT → CNT_ACK → WDATA ⇄ WDATA_ACK.
- The read path runs RDATA → RACK. From RACK it goes back to RDATA on ACK and to ST_SKIP on NACK.

Every state change happens on an SCL falling edge, except the three forced ones.

Top module: `cfgi2c_top`

## Requirements
- R1: After reset, register 0 reads 0x0C, registers 1 through 6 read 0xFF, and SDA is not pulled low.
- R2: The address byte 0xD2 is acknowledged by pulling SDA low during the ninth SCL pulse. An address byte with any other 7-bit address gets no acknowledge, and the bytes that follow change no register.
- R3: After a write address, the command-code byte and the byte-count byte are both acknowledged, and neither value is stored anywhere.
- R4: Data bytes of a write are acknowledged and stored into registers 0, 1, 2, … in ascending order. After a STOP that follows k complete data bytes, registers k and above keep their earlier values.
- R5: Data bytes beyond register 6 are acknowledged and discarded, leaving all seven registers unchanged.
- R6: Address byte 0xD3 is acknowledged. The slave then sends register 0, 1, … in turn, one byte per controller ACK, until the controller answers NACK. Positions past register 6 return 0xFF.
- R7: While `pd_hiz` is 1, SDA is never pulled low, no byte is acknowledged, and no register changes.
- R8: `op_mode` equals {register0 bit 0, register0 bit 1}, with 0 = normal, 1 = outputs tristated, 2 = spread spectrum on, 3 = test. `fix0_48m` is register0 bit 2, `fix1_48m` is bit 3, `spread_narrow` is bit 4 (1 = 0.6 %, 0 = 1.8 %), and `spread_down` is bit 5 (1 = down-spread, 0 = centred).
- R9: A repeated START aborts the current transfer and begins a new address phase. A new write again starts at register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16× the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| pd_hiz | input | 1 | Power-down tristate: releases SDA and parks the controller |
| sda_pull_low | output | 1 | 1 = pull SDA low (open-drain enable) |
| ctl_func | output | 8 | Register 0, function and frequency control |
| en_cpu_fix | output | 8 | Register 1, CPU clocks and fixed-output enables |
| en_pci | output | 8 | Register 2, PCI clock enables |
| en_sdram | output | 8 | Register 3, SDRAM clock enables |
| cfg_aux4 | output | 8 | Register 4 |
| en_periph | output | 8 | Register 5, IOAPIC and reference enables |
| cfg_aux6 | output | 8 | Register 6 |
| op_mode | output | 2 | Decoded operating mode |
| fix0_48m | output | 1 | Fixed output 0 at 48 MHz (1) or 24 MHz (0) |
| fix1_48m | output | 1 | Fixed output 1 at 48 MHz (1) or 24 MHz (0) |
| spread_narrow | output | 1 | Spread amount select |
| spread_down | output | 1 | Spread type select |

## Verification
A vector table drives single-byte writes of register 0 whose bit patterns reach all four mode codes and both values of each frequency and spread field. This tells apart a swapped mode-bit order or a shifted field from correct decoding.

Directed transfers cover the following:
- A nine-byte write separates a correct auto-increment from a stuck or off-by-one pointer, and from stored dummy bytes.
- A two-byte write shows that untouched registers survive.
- A foreign address shows that the address is really compared.
- A nine-byte read exposes wrong ordering and wrong padding past the end.
- The tristate test and the repeated-START test separate the forced transitions from the normal flow.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

    localparam int              BYTE_W   = 8;
    localparam int              NUM_REGS = 7;
    localparam int              PTR_W    = $clog2(NUM_REGS + 1);
    localparam int              CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [6:0]      DEV_ADDR = 7'h69;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_CNT,
        ST_CNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } i2c_state_e;

    // Power-up value of each configuration register.
    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        if (idx == 0) begin
            return 8'h0C;
        end
        return 8'hFF;
    endfunction

endpackage

// File: rtl/cfgi2c_sync.sv
module cfgi2c_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] now_o,
    output logic [LINES-1:0] prev_o
);

    // STAGES synchronising flops plus one history flop per line; idle bus is high.
    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES:0] pipe;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe <= '1;
                end else begin
                    pipe <= {pipe[STAGES-1:0], raw_i[g]};
                end
            end

            assign now_o[g]  = pipe[STAGES-1];
            assign prev_o[g] = pipe[STAGES];
        end
    endgenerate

endmodule

// File: rtl/cfgi2c_regs.sv
module cfgi2c_regs
    import cfgi2c_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [PTR_W-1:0]           wr_idx,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [PTR_W-1:0]           rd_idx,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);

    logic [BYTE_W-1:0] regs_q [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= reg_default(i);
            end
        end else if (wr_en) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_idx == PTR_W'(i)) begin
                    regs_q[i] <= wr_data;
                end
            end
        end
    end

    // Read port: positions beyond the last register return all ones.
    always_comb begin
        rd_data = '1;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == PTR_W'(i)) begin
                rd_data = regs_q[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            regs_flat[i*BYTE_W +: BYTE_W] = regs_q[i];
        end
    end

    // R5: the controller never issues a store outside the register file
    a_r5_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < PTR_W'(NUM_REGS)));

endmodule

// File: rtl/cfgi2c_fsm.sv
module cfgi2c_fsm
    import cfgi2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              scl_now,
    input  logic              scl_prev,
    input  logic              sda_now,
    input  logic              sda_prev,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [PTR_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe
);

    localparam logic [PTR_W-1:0] PTR_END   = PTR_W'(NUM_REGS);
    localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(BYTE_W);

    i2c_state_e        state, state_nx;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txsh;
    logic [CNT_W-1:0]  bitcnt;
    logic [PTR_W-1:0]  ptr;
    logic              nack;

    logic scl_rise, scl_fall, start_c, stop_c, byte_full;

    assign scl_rise  =  scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now &  scl_prev;
    assign start_c   =  scl_now &  scl_prev &  sda_prev & ~sda_now;
    assign stop_c    =  scl_now &  scl_prev & ~sda_prev &  sda_now;
    assign byte_full = (bitcnt == BITS_FULL);

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (hold) begin
            state_nx = ST_IDLE;
        end else if (start_c) begin
            state_nx = ST_ADDR;
        end else if (stop_c) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_SKIP: ;
                ST_ADDR:
                    if (scl_fall && byte_full)
                        state_nx = (shreg[BYTE_W-1:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK:
                    if (scl_fall) state_nx = shreg[0] ? ST_RDATA : ST_CMD;
                ST_CMD:
                    if (scl_fall && byte_full) state_nx = ST_CMD_ACK;
                ST_CMD_ACK:
                    if (scl_fall) state_nx = ST_CNT;
                ST_CNT:
                    if (scl_fall && byte_full) state_nx = ST_CNT_ACK;
                ST_CNT_ACK:
                    if (scl_fall) state_nx = ST_WDATA;
                ST_WDATA:
                    if (scl_fall && byte_full) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK:
                    if (scl_fall) state_nx = ST_WDATA;
                ST_RDATA:
                    if (scl_fall && byte_full) state_nx = ST_RACK;
                ST_RACK:
                    if (scl_fall) state_nx = nack ? ST_SKIP : ST_RDATA;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Shift, count and pointer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            txsh   <= '1;
            bitcnt <= '0;
            ptr    <= '0;
            nack   <= 1'b0;
        end else if (hold || start_c) begin
            bitcnt <= '0;
            ptr    <= '0;
        end else if (stop_c) begin
            bitcnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_CMD, ST_CNT, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_now};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (state == ST_WDATA && scl_fall && byte_full && ptr != PTR_END) begin
                        ptr <= ptr + 1'b1;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (shreg[0]) begin
                            txsh <= rd_data;
                            ptr  <= ptr + 1'b1;
                        end
                    end
                end
                ST_CMD_ACK, ST_CNT_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) bitcnt <= '0;
                end
                ST_RDATA: begin
                    if (scl_rise) bitcnt <= bitcnt + 1'b1;
                    if (scl_fall && !byte_full) txsh <= {txsh[BYTE_W-2:0], 1'b1};
                end
                ST_RACK: begin
                    if (scl_rise) nack <= sda_now;
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (!nack) begin
                            txsh <= rd_data;
                            if (ptr != PTR_END) ptr <= ptr + 1'b1;
                        end
                    end
                end
                ST_IDLE, ST_SKIP: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_CNT_ACK, ST_WDATA_ACK: sda_oe = ~hold;
            ST_RDATA:                                          sda_oe = ~hold & ~txsh[BYTE_W-1];
            default:                                           sda_oe = 1'b0;
        endcase
        wr_en   = (state == ST_WDATA) && scl_fall && byte_full && (ptr != PTR_END)
                  && !hold && !start_c && !stop_c;
        wr_idx  = ptr;
        wr_data = shreg;
        rd_idx  = ptr;
    end

    // R7: the tristate request parks the controller one cycle later
    a_r7_hiz_parks: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (state == ST_IDLE));

    // R9: a START always reopens the address phase with an empty bit count
    a_r9_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (start_c && !hold) |=> (state == ST_ADDR && bitcnt == '0));

    // R4: a STOP closes any transfer
    a_r4_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_c && !hold) |=> (state == ST_IDLE));

    // R2: address acknowledge only follows a matching address
    a_r2_ack_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> (shreg[BYTE_W-1:1] == DEV_ADDR));

endmodule

// File: rtl/cfgi2c_top.sv
module cfgi2c_top
    import cfgi2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       pd_hiz,
    output logic       sda_pull_low,
    output logic [7:0] ctl_func,
    output logic [7:0] en_cpu_fix,
    output logic [7:0] en_pci,
    output logic [7:0] en_sdram,
    output logic [7:0] cfg_aux4,
    output logic [7:0] en_periph,
    output logic [7:0] cfg_aux6,
    output logic [1:0] op_mode,
    output logic       fix0_48m,
    output logic       fix1_48m,
    output logic       spread_narrow,
    output logic       spread_down
);

    logic [1:0]                 ln_now, ln_prev;
    logic                       wr_en;
    logic [PTR_W-1:0]           wr_idx, rd_idx;
    logic [BYTE_W-1:0]          wr_data, rd_data;
    logic [NUM_REGS*BYTE_W-1:0] regs_flat;

    cfgi2c_sync #(.LINES(2), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sda_i, scl_i}),
        .now_o  (ln_now),
        .prev_o (ln_prev)
    );

    cfgi2c_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (pd_hiz),
        .scl_now  (ln_now[0]),
        .scl_prev (ln_prev[0]),
        .sda_now  (ln_now[1]),
        .sda_prev (ln_prev[1]),
        .rd_data  (rd_data),
        .rd_idx   (rd_idx),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .sda_oe   (sda_pull_low)
    );

    cfgi2c_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .regs_flat (regs_flat)
    );

    assign ctl_func   = regs_flat[0*BYTE_W +: BYTE_W];
    assign en_cpu_fix = regs_flat[1*BYTE_W +: BYTE_W];
    assign en_pci     = regs_flat[2*BYTE_W +: BYTE_W];
    assign en_sdram   = regs_flat[3*BYTE_W +: BYTE_W];
    assign cfg_aux4   = regs_flat[4*BYTE_W +: BYTE_W];
    assign en_periph  = regs_flat[5*BYTE_W +: BYTE_W];
    assign cfg_aux6   = regs_flat[6*BYTE_W +: BYTE_W];

    // Mode code is read with bit 0 as its upper digit.
    assign op_mode       = {ctl_func[0], ctl_func[1]};
    assign fix0_48m      = ctl_func[2];
    assign fix1_48m      = ctl_func[3];
    assign spread_narrow = ctl_func[4];
    assign spread_down   = ctl_func[5];

    // R7: the register file is frozen while the tristate request is high
    a_r7_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        pd_hiz |=> $stable(regs_flat));

endmodule

// File: tb/sim_cfgi2c_top.sv
module sim_cfgi2c_top;

    localparam int Q    = 20;
    localparam int WDOG = 190000;
    // {byte written to register 0, op_mode, fix0, fix1, narrow, down}
    localparam logic [13:0] VEC [6] = '{
        {8'h0C, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h01, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h02, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h03, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h34, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1},
        {8'h29, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n, scl, m_sda, pd_hiz;
    logic sda_line, sda_pull_low;
    logic [7:0] ctl_func, en_cpu_fix, en_pci, en_sdram, cfg_aux4, en_periph, cfg_aux6;
    logic [1:0] op_mode;
    logic fix0_48m, fix1_48m, spread_narrow, spread_down;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] exp_q [7];
    logic [7:0] obs [7];
    logic [7:0] wbuf [12];
    logic [7:0] rbuf [12];
    bit         ack_q [16];

    always #4 clk = ~clk;
    assign sda_line = m_sda & ~sda_pull_low;
    assign obs[0] = ctl_func;
    assign obs[1] = en_cpu_fix;
    assign obs[2] = en_pci;
    assign obs[3] = en_sdram;
    assign obs[4] = cfg_aux4;
    assign obs[5] = en_periph;
    assign obs[6] = cfg_aux6;

    cfgi2c_top u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .pd_hiz(pd_hiz),
        .sda_pull_low(sda_pull_low), .ctl_func(ctl_func), .en_cpu_fix(en_cpu_fix),
        .en_pci(en_pci), .en_sdram(en_sdram), .cfg_aux4(cfg_aux4), .en_periph(en_periph),
        .cfg_aux6(cfg_aux6), .op_mode(op_mode), .fix0_48m(fix0_48m), .fix1_48m(fix1_48m),
        .spread_narrow(spread_narrow), .spread_down(spread_down)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exv);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hq(); scl = 1'b1; hq(); m_sda = 1'b0; hq(); scl = 1'b0; hq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hq(); scl = 1'b1; hq(); m_sda = 1'b1; hq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hq(); scl = 1'b1; hq(); hq(); scl = 1'b0; hq();
        end
        m_sda = 1'b1; hq(); scl = 1'b1; hq(); ack = !sda_line; hq(); scl = 1'b0; hq();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        b = '0;
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            hq(); scl = 1'b1; hq(); b = {b[6:0], sda_line}; hq(); scl = 1'b0; hq();
        end
        m_sda = give_ack ? 1'b0 : 1'b1;
        hq(); scl = 1'b1; hq(); hq(); scl = 1'b0; hq();
        m_sda = 1'b1;
    endtask

    // address, command, count, then n data bytes from wbuf; acks into ack_q
    task automatic do_write(input logic [7:0] addr, input int n);
        bus_start();
        send_byte(addr, ack_q[0]);
        send_byte(8'hA5, ack_q[1]);
        send_byte(8'h3C, ack_q[2]);
        for (int i = 0; i < n; i++) send_byte(wbuf[i], ack_q[3+i]);
        bus_stop();
    endtask

    task automatic do_read(input int n);
        bus_start();
        send_byte(8'hD3, ack_q[0]);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic chk_regs(input string req);
        for (int i = 0; i < 7; i++) chk(obs[i] === exp_q[i], req, obs[i], exp_q[i]);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; pd_hiz = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: power-up contents and released SDA
        exp_q[0] = 8'h0C;
        for (int i = 1; i < 7; i++) exp_q[i] = 8'hFF;
        chk_regs("R1 reset value");
        chk(sda_pull_low == 1'b0, "R1 sda released", sda_pull_low, 0);

        // R8: decode table, one single-byte write per vector
        for (int v = 0; v < 6; v++) begin
            wbuf[0] = VEC[v][13:6];
            do_write(8'hD2, 1);
            for (int k = 0; k < 4; k++) chk(ack_q[k], "R3 ack on single write", ack_q[k], 1);
            exp_q[0] = VEC[v][13:6];
            chk(ctl_func === VEC[v][13:6], "R8 register 0", ctl_func, VEC[v][13:6]);
            chk({op_mode, fix0_48m, fix1_48m, spread_narrow, spread_down} === VEC[v][5:0],
                "R8 decoded fields", {op_mode, fix0_48m, fix1_48m, spread_narrow, spread_down},
                VEC[v][5:0]);
        end
        chk_regs("R4 only register 0 touched");

        // R3 R4 R5: nine data bytes, last two past the end
        for (int i = 0; i < 9; i++) wbuf[i] = 8'h11 * (i + 1);
        do_write(8'hD2, 9);
        chk(ack_q[1] && ack_q[2], "R3 dummy bytes acked", {ack_q[1], ack_q[2]}, 3);
        for (int i = 0; i < 7; i++) chk(ack_q[3+i], "R4 data byte acked", ack_q[3+i], 1);
        chk(ack_q[10] && ack_q[11], "R5 extra bytes acked", {ack_q[10], ack_q[11]}, 3);
        for (int i = 0; i < 7; i++) exp_q[i] = wbuf[i];
        chk_regs("R5 R3 R4 sequential store");

        // R4: partial write stops after two bytes
        wbuf[0] = 8'hC1; wbuf[1] = 8'hC2;
        do_write(8'hD2, 2);
        exp_q[0] = 8'hC1; exp_q[1] = 8'hC2;
        chk_regs("R4 partial write");

        // R2: foreign address
        wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'h00;
        do_write(8'hA4, 3);
        chk(ack_q[0] == 1'b0, "R2 foreign address not acked", ack_q[0], 0);
        chk_regs("R2 foreign address ignored");

        // R6: read nine positions
        do_read(9);
        chk(ack_q[0], "R6 read address acked", ack_q[0], 1);
        for (int i = 0; i < 7; i++) chk(rbuf[i] === exp_q[i], "R6 read order", rbuf[i], exp_q[i]);
        chk(rbuf[7] === 8'hFF && rbuf[8] === 8'hFF, "R6 read past end", {rbuf[7], rbuf[8]}, 16'hFFFF);

        // R7: tristate request
        pd_hiz = 1'b1;
        repeat (3) @(negedge clk);
        wbuf[0] = 8'h77; wbuf[1] = 8'h66;
        do_write(8'hD2, 2);
        chk(ack_q[0] == 0 && ack_q[3] == 0, "R7 no acknowledge in hiz", {ack_q[0], ack_q[3]}, 0);
        chk(sda_pull_low == 1'b0, "R7 sda released", sda_pull_low, 0);
        chk_regs("R7 registers held");
        pd_hiz = 1'b0;
        repeat (3) @(negedge clk);
        do_read(2);
        chk(rbuf[0] === exp_q[0] && rbuf[1] === exp_q[1], "R7 contents after hiz",
            {rbuf[0], rbuf[1]}, {exp_q[0], exp_q[1]});

        // R9: repeated START restarts at register 0
        bus_start();
        send_byte(8'hD2, ack_q[0]); send_byte(8'h01, ack_q[1]);
        send_byte(8'h01, ack_q[2]); send_byte(8'h5A, ack_q[3]);
        m_sda = 1'b1; hq(); scl = 1'b1; hq(); m_sda = 1'b0; hq(); scl = 1'b0; hq();
        send_byte(8'hD2, ack_q[4]); send_byte(8'h02, ack_q[5]);
        send_byte(8'h02, ack_q[6]); send_byte(8'h6B, ack_q[7]);
        bus_stop();
        chk(ack_q[4], "R9 address after repeated start acked", ack_q[4], 1);
        exp_q[0] = 8'h6B;
        chk_regs("R9 restart at register 0");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule